// File: doc/BRIEF.md
# Burst SRAM Control Front-End

This block is the synchronous control path of a burst-capable static RAM whose 18-bit word is split into two 9-bit byte lanes. On each rising clock edge it samples three chip enables, two address strobes (one for a processor, one for a controller), an advance input and a hierarchy of write controls. From these it decides whether the cycle starts a burst, continues one, deselects the device, reads, or writes some or all lanes. Read data leaves through an output register one edge after the read cycle. The data bus is modelled as a value plus a drive enable, with the enable low standing for high impedance.

A loaded address is the start of a four-beat burst on its two lowest bits. A static strap input picks interleaved order (start XOR beat count) or linear order (start plus beat count, modulo four). The output enable and the sleep input act on the drive enable without waiting for a clock edge. While sleep is high, every edge is ignored except that the device drops out of selection, and the stored words are kept. The storage is a small register array with one write enable per lane.

Top module: `bsram_front`

## Requirements
- R1: After synchronous reset the device is deselected and `dq_en_o` is low; an advance with no strobe does not start a read.
- R2: A strobe sampled with `ce_n_i` low, `ce2_i` high and `ce3_n_i` low loads `addr_i` as the burst start, and that cycle's access uses `addr_i` itself.
- R3: The processor strobe is ignored when `ce_n_i` is high; a burst in progress keeps going as if no strobe was present.
- R4: A strobe taken while `ce2_i` is low or `ce3_n_i` is high deselects the device; later cycles with no strobe neither read nor write until a new address is loaded.
- R5: With `order_i` high, each cycle with `adv_n_i` low and no strobe moves to the next beat. The two low address bits equal the start bits XOR the beat count 0,1,2,3, and the count wraps to 0 after the fourth beat.
- R6: With `order_i` low, the two low address bits equal the start bits plus the beat count, modulo four. The upper address bits never change during a burst.
- R7: `gw_n_i` low writes both lanes: bits 8:0 form lane 0 and bits 17:9 form lane 1.
- R8: With `gw_n_i` high and `bw_n_i` low, each lane whose bit of `lane_n_i` is low (bit 0 for lane 0) is written. If no lane bit is low, the cycle is a read.
- R9: With `gw_n_i` and `bw_n_i` both high, the cycle is a read whatever `lane_n_i` holds.
- R10: The data of a read cycle appears on `dq_o` after that cycle's clock edge. It is driven only while `oe_n_i` is low, and raising `oe_n_i` releases the bus at once.
- R11: While `sleep_i` is high, `dq_en_o` is low, strobes and writes have no effect, the stored contents are kept, and the device is left deselected.
- R12: When both strobes are active with `ce_n_i` low, the processor strobe wins: the cycle is a read at `addr_i` and its write controls are ignored.
- R13: A selected cycle with no strobe and `adv_n_i` high repeats the access at the current address, as a read or as a write according to the write controls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge samples all synchronous inputs |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_i | input | 1 | Asynchronous sleep, active high |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| order_i | input | 1 | Burst order strap: 1 interleaved, 0 linear |
| ce_n_i | input | 1 | Master chip enable, active low |
| ce2_i | input | 1 | Secondary chip enable, active high |
| ce3_n_i | input | 1 | Secondary chip enable, active low |
| strb_p_n_i | input | 1 | Processor address strobe, active low |
| strb_c_n_i | input | 1 | Controller address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| gw_n_i | input | 1 | Global write, active low |
| bw_n_i | input | 1 | Byte write enable, active low |
| lane_n_i | input | 2 | Per-lane write bits, active low, bit 0 for lane 0 |
| addr_i | input | AW | Word address |
| wdata_i | input | 2*LANE_W | Write data |
| dq_o | output | 2*LANE_W | Read data, zero when not driven |
| dq_en_o | output | 1 | Data bus drive enable (low stands for high impedance) |

## Verification
The bench goes after the wrap of both burst orders from a start that is not zero. A design that mixes up XOR and add, or that carries into bit 2, returns words from the wrong addresses. It drives a processor strobe with the master enable off in the middle of a burst, and both strobes together with a global write, so a design that obeys the blocked strobe restarts the burst and a design that lets the wrong strobe win overwrites the word. It tests single-lane writes and byte-write cycles with no lane selected, which catch swapped lanes or a stray write. It also checks the bus release by output enable and by sleep, and writes attempted during sleep, so a design that waits for a clock edge, or that keeps working in sleep, corrupts the later read-back.

// File: rtl/bsram_pkg.sv
// Shared definitions for the burst SRAM front-end.
// Assumes a word made of exactly two byte lanes.
package bsram_pkg;
    localparam int unsigned NLANES = 2;

    // Per-cycle decision handed from the decoder to the burst and array logic.
    typedef struct packed {
        logic              load;   // new start address taken
        logic              desel;  // strobe with an inactive enable
        logic              cont;   // selected, no strobe
        logic              adv;    // continuing cycle that steps the beat
        logic [NLANES-1:0] wr;     // lane write enables
        logic              rd;     // read access this cycle
    } ctl_t;
endpackage

// File: rtl/bsram_ctl.sv
// Cycle decoder: turns enables, strobes, advance and write controls into
// one decision per clock edge. Assumes sleep_i already reflects the pin level.
module bsram_ctl
    import bsram_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_i,
    input  logic              ce_n_i,
    input  logic              ce2_i,
    input  logic              ce3_n_i,
    input  logic              strb_p_n_i,
    input  logic              strb_c_n_i,
    input  logic              adv_n_i,
    input  logic              gw_n_i,
    input  logic              bw_n_i,
    input  logic [NLANES-1:0] lane_n_i,
    input  logic              sel_i,
    output ctl_t              ctl_o
);
    logic              p_go;
    logic              c_go;
    logic              en_all;
    logic [NLANES-1:0] wr_dec;

    // Strobe qualification and write-hierarchy decode.
    always_comb begin
        p_go   = !strb_p_n_i && !ce_n_i;
        c_go   = !strb_c_n_i && !p_go;
        en_all = !ce_n_i && ce2_i && !ce3_n_i;
        if (!gw_n_i)      wr_dec = '1;
        else if (!bw_n_i) wr_dec = ~lane_n_i;
        else              wr_dec = '0;
    end

    // Cycle decision; everything stays idle while asleep.
    always_comb begin
        ctl_o = '0;
        if (!sleep_i) begin
            if (p_go || c_go) begin
                ctl_o.load  = en_all;
                ctl_o.desel = !en_all;
            end else if (sel_i) begin
                ctl_o.cont = 1'b1;
                ctl_o.adv  = !adv_n_i;
            end
            if ((ctl_o.load && c_go) || ctl_o.cont) ctl_o.wr = wr_dec;
            ctl_o.rd = (ctl_o.load || ctl_o.cont) && (ctl_o.wr == '0);
        end
    end

    // R12: a processor-strobe cycle never writes.
    a_r12_pstrobe_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_p_n_i && !ce_n_i) |-> (ctl_o.wr == '0));

    // R3: blocked processor strobe neither loads nor deselects.
    a_r3_master_blocks_pstrobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_p_n_i && ce_n_i && strb_c_n_i) |-> (!ctl_o.load && !ctl_o.desel));

    // R9: no write without global or byte write enable.
    a_r9_no_enable_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (gw_n_i && bw_n_i) |-> (ctl_o.wr == '0));
endmodule

// File: rtl/bsram_burst.sv
// Burst address generator: holds the start address, a 2-bit beat count and
// the selected flag, and forms the address of the current cycle.
// Assumes AW >= 3 so that upper address bits exist above the burst field.
module bsram_burst #(
    parameter int unsigned AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sleep_i,
    input  logic          order_i,
    input  logic          load_i,
    input  logic          desel_i,
    input  logic          adv_i,
    input  logic [AW-1:0] addr_i,
    output logic          sel_o,
    output logic [AW-1:0] addr_o
);
    localparam int unsigned BW = 2;

    logic [AW-1:0] base_q;
    logic [BW-1:0] cnt_q;
    logic          sel_q;
    logic [AW-1:0] start;
    logic [BW-1:0] step;
    logic [BW-1:0] low;

    // Burst state update: load, deselect, advance, or drop selection in sleep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
            sel_q  <= 1'b0;
        end else if (sleep_i) begin
            sel_q  <= 1'b0;
        end else if (load_i) begin
            base_q <= addr_i;
            cnt_q  <= '0;
            sel_q  <= 1'b1;
        end else if (desel_i) begin
            sel_q  <= 1'b0;
        end else if (adv_i) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // Address of this cycle in the selected burst order.
    always_comb begin
        start  = load_i ? addr_i : base_q;
        step   = load_i ? '0 : (adv_i ? cnt_q + 1'b1 : cnt_q);
        low    = order_i ? (start[BW-1:0] ^ step) : (start[BW-1:0] + step);
        addr_o = {start[AW-1:BW], low};
        sel_o  = sel_q;
    end

    // R2: a load restarts the burst at the sampled address.
    a_r2_load_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (sel_q && cnt_q == '0 && base_q == $past(addr_i)));

    // R5: an advance steps the beat count by one, wrapping.
    a_r5_advance_steps: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i |=> (cnt_q == $past(cnt_q) + 2'd1));

    // R4: a deselect drops selection.
    a_r4_desel_drops: assert property (@(posedge clk) disable iff (!rst_n)
        desel_i |=> !sel_q);

    // R11: sleep leaves the start address alone and deselects.
    a_r11_sleep_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |=> (!sel_q && $stable(base_q)));
endmodule

// File: rtl/bsram_array.sv
// Storage array: one register bank per byte lane, written by its own lane
// enable and read into a registered output. No reset on the contents.
module bsram_array
    import bsram_pkg::*;
#(
    parameter int unsigned AW     = 4,
    parameter int unsigned LANE_W = 9
) (
    input  logic                     clk,
    input  logic [AW-1:0]            addr_i,
    input  logic [NLANES-1:0]        wr_i,
    input  logic                     rd_i,
    input  logic [NLANES*LANE_W-1:0] wdata_i,
    output logic [NLANES*LANE_W-1:0] rdata_o
);
    localparam int unsigned DEPTH = 1 << AW;

    for (genvar ln = 0; ln < NLANES; ln++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Lane write and registered lane read.
        always_ff @(posedge clk) begin
            if (wr_i[ln]) mem[addr_i] <= wdata_i[ln*LANE_W +: LANE_W];
            if (rd_i)     rdata_o[ln*LANE_W +: LANE_W] <= mem[addr_i];
        end
    end
endmodule

// File: rtl/bsram_front.sv
// Top of the burst SRAM front-end: decoder, burst generator, storage and the
// read-valid register that, with output enable and sleep, gates the bus.
// Assumes order_i is a static strap; oe_n_i and sleep_i act without a clock.
module bsram_front
    import bsram_pkg::*;
#(
    parameter int unsigned AW     = 4,
    parameter int unsigned LANE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sleep_i,
    input  logic                     oe_n_i,
    input  logic                     order_i,
    input  logic                     ce_n_i,
    input  logic                     ce2_i,
    input  logic                     ce3_n_i,
    input  logic                     strb_p_n_i,
    input  logic                     strb_c_n_i,
    input  logic                     adv_n_i,
    input  logic                     gw_n_i,
    input  logic                     bw_n_i,
    input  logic [NLANES-1:0]        lane_n_i,
    input  logic [AW-1:0]            addr_i,
    input  logic [NLANES*LANE_W-1:0] wdata_i,
    output logic [NLANES*LANE_W-1:0] dq_o,
    output logic                     dq_en_o
);
    localparam int unsigned DW = NLANES * LANE_W;

    ctl_t          ctl;
    logic          sel;
    logic [AW-1:0] cur_addr;
    logic [DW-1:0] rdata;
    logic          rd_valid_q;

    bsram_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_i    (sleep_i),
        .ce_n_i     (ce_n_i),
        .ce2_i      (ce2_i),
        .ce3_n_i    (ce3_n_i),
        .strb_p_n_i (strb_p_n_i),
        .strb_c_n_i (strb_c_n_i),
        .adv_n_i    (adv_n_i),
        .gw_n_i     (gw_n_i),
        .bw_n_i     (bw_n_i),
        .lane_n_i   (lane_n_i),
        .sel_i      (sel),
        .ctl_o      (ctl)
    );

    bsram_burst #(.AW(AW)) u_burst (
        .clk     (clk),
        .rst_n   (rst_n),
        .sleep_i (sleep_i),
        .order_i (order_i),
        .load_i  (ctl.load),
        .desel_i (ctl.desel),
        .adv_i   (ctl.adv),
        .addr_i  (addr_i),
        .sel_o   (sel),
        .addr_o  (cur_addr)
    );

    bsram_array #(.AW(AW), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .addr_i  (cur_addr),
        .wr_i    (ctl.wr),
        .rd_i    (ctl.rd),
        .wdata_i (wdata_i),
        .rdata_o (rdata)
    );

    // Marks that the output register holds data of a read cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_valid_q <= 1'b0;
        else        rd_valid_q <= ctl.rd;
    end

    // Asynchronous bus gating by output enable and sleep.
    always_comb begin
        dq_en_o = rd_valid_q && !oe_n_i && !sleep_i;
        dq_o    = dq_en_o ? rdata : '0;
    end

    // R11: no drive while asleep.
    a_r11_sleep_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |-> !dq_en_o);

    // R10: no drive while output enable is inactive.
    a_r10_oe_gates: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n_i |-> !dq_en_o);

    // R4: a deselect cycle produces no drive after its edge.
    a_r4_desel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.desel |=> !rd_valid_q);
endmodule

// File: tb/bsram_front_tb_top.sv
module bsram_front_tb_top;
    localparam int AW = 4;
    localparam int DW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sleep_i = 1'b0, oe_n_i = 1'b0, order_i = 1'b1;
    logic          ce_n_i = 1'b0, ce2_i = 1'b1, ce3_n_i = 1'b0;
    logic          strb_p_n_i = 1'b1, strb_c_n_i = 1'b1, adv_n_i = 1'b1;
    logic          gw_n_i = 1'b1, bw_n_i = 1'b1;
    logic [1:0]    lane_n_i = 2'b11;
    logic [AW-1:0] addr_i = '0;
    logic [DW-1:0] wdata_i = '0;
    logic [DW-1:0] dq_o;
    logic          dq_en_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [DW-1:0] model [16];
    logic [DW-1:0] exp_q [$];
    string         tag_q [$];

    always #5 clk = ~clk;

    bsram_front dut_i (
        .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .oe_n_i(oe_n_i),
        .order_i(order_i), .ce_n_i(ce_n_i), .ce2_i(ce2_i), .ce3_n_i(ce3_n_i),
        .strb_p_n_i(strb_p_n_i), .strb_c_n_i(strb_c_n_i), .adv_n_i(adv_n_i),
        .gw_n_i(gw_n_i), .bw_n_i(bw_n_i), .lane_n_i(lane_n_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .dq_o(dq_o), .dq_en_o(dq_en_o)
    );

    function automatic logic [AW-1:0] ilv(input logic [AW-1:0] s, input logic [1:0] k);
        return {s[AW-1:2], s[1:0] ^ k};
    endfunction

    function automatic logic [AW-1:0] lin(input logic [AW-1:0] s, input logic [1:0] k);
        return {s[AW-1:2], s[1:0] + k};
    endfunction

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One bus cycle: drive after the edge, enables default to active.
    task automatic cyc(input logic p_n, input logic c_n, input logic a_n,
                       input logic g_n, input logic b_n, input logic [1:0] ln,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(posedge clk); #1;
        strb_p_n_i = p_n; strb_c_n_i = c_n; adv_n_i = a_n;
        gw_n_i = g_n; bw_n_i = b_n; lane_n_i = ln;
        addr_i = a; wdata_i = d;
        ce_n_i = 1'b0; ce2_i = 1'b1; ce3_n_i = 1'b0;
    endtask

    task automatic push(input logic [DW-1:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic p_read(input logic [AW-1:0] a, input string t);
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'b11, a, '0);
        push(model[a], t);
    endtask

    task automatic adv_read(input logic [AW-1:0] ea, input string t);
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2'b11, '0, '0);
        push(model[ea], t);
    endtask

    task automatic desel();
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'b11, '0, '0);
        ce2_i = 1'b0;
    endtask

    task automatic quiet_check(input string t);
        @(negedge clk);
        check(dq_en_o == 1'b0, t, {17'd0, dq_en_o}, '0);
    endtask

    // Scoreboard monitor: every drive must match the oldest expected word.
    always @(negedge clk) begin
        if (rst_n && dq_en_o) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "unexpected drive (R4/R11/R1)", dq_o, 'x);
            end else begin
                logic [DW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(dq_o === e, t, dq_o, e);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: quiet after reset, advance alone starts nothing.
        quiet_check("R1 reset drive");
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2'b11, '0, '0);
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2'b11, '0, '0);
        quiet_check("R1 advance after reset");

        // R7/R2: fill every word with a global write at a controller strobe.
        for (int a = 0; a < 16; a++) begin
            logic [DW-1:0] d;
            d = 18'h01000 + 18'(a) * 18'h00111;
            cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'b11, AW'(a), d);
            model[a] = d;
        end
        p_read(4'hA, "R7 global write readback");
        p_read(4'h2, "R2 load address");

        // R5: interleaved burst from 5, wrapping back to 5.
        order_i = 1'b1;
        p_read(4'h5, "R5 beat0");
        adv_read(ilv(4'h5, 2'd1), "R5 beat1");
        adv_read(ilv(4'h5, 2'd2), "R5 beat2");
        adv_read(ilv(4'h5, 2'd3), "R5 beat3");
        adv_read(ilv(4'h5, 2'd0), "R5 wrap");

        // R6: linear burst from 6, wrapping inside the 4-word group.
        desel();
        order_i = 1'b0;
        p_read(4'h6, "R6 beat0");
        adv_read(lin(4'h6, 2'd1), "R6 beat1");
        adv_read(lin(4'h6, 2'd2), "R6 beat2");
        adv_read(lin(4'h6, 2'd3), "R6 beat3");
        adv_read(lin(4'h6, 2'd0), "R6 wrap");
        desel();
        order_i = 1'b1;

        // R8: lane 0 only (lane_n_i = 2'b10).
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'b10, 4'h3, 18'h2AB55);
        model[3][8:0] = 9'h155;
        p_read(4'h3, "R8 lane0 write");
        // R8: lane 1 only (lane_n_i = 2'b01).
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'b01, 4'h8, 18'h3C0F0);
        model[8][17:9] = 9'h1E0;
        p_read(4'h8, "R8 lane1 write");
        // R8: byte write enabled but no lane selected reads.
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'b11, 4'h4, 18'h3FFFF);
        push(model[4], "R8 no lane is read");
        // R9: lane bits ignored without byte write enable.
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 4'h7, 18'h3FFFF);
        push(model[7], "R9 read despite lane bits");
        p_read(4'h7, "R9 word unchanged");

        // R3: processor strobe with master enable off continues the burst.
        p_read(4'h0, "R3 beat0");
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 4'h9, '0);
        ce_n_i = 1'b1;
        push(model[ilv(4'h0, 2'd1)], "R3 blocked strobe");

        // R4: deselect via ce2 low, then via ce3_n high.
        desel();
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2'b11, '0, '0);
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, '0, 18'h3FFFF);
        quiet_check("R4 after ce2 deselect");
        p_read(4'h2, "R4 reload");
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'b11, '0, '0);
        ce3_n_i = 1'b1;
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2'b11, '0, '0);
        quiet_check("R4 after ce3 deselect");
        p_read(4'h1, "R4 ignored write kept word");

        // R12: both strobes with a global write: read, no write.
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'b11, 4'hC, 18'h3FFFF);
        push(model[12], "R12 priority read");
        desel();
        p_read(4'hC, "R12 word not written");

        // R13: hold repeats the read, and repeats a write.
        p_read(4'h9, "R13 load");
        cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'b11, 4'h0, '0);
        push(model[9], "R13 held read");
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'b11, 4'hA, 18'h11111);
        model[10] = 18'h11111;
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 2'b11, 4'h0, 18'h22222);
        model[10] = 18'h22222;
        p_read(4'hA, "R13 held write");

        // R10: output enable gates the bus without a clock edge.
        desel();
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'b11, 4'hB, '0);
        oe_n_i = 1'b1;
        desel();
        @(negedge clk);
        check(dq_en_o == 1'b0, "R10 oe high releases", {17'd0, dq_en_o}, '0);
        #1 oe_n_i = 1'b0;
        #1 check(dq_en_o == 1'b1 && dq_o == model[11], "R10 oe low drives", dq_o, model[11]);

        // R11: sleep ignores strobes and writes, keeps data, deselects.
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'b11, 4'h0, 18'h3FFFF);
        sleep_i = 1'b1;
        quiet_check("R11 sleep no drive");
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 2'b11, 4'h1, 18'h3FFFF);
        quiet_check("R11 sleep strobe ignored");
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 4'h0, '0);
        sleep_i = 1'b0;
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 4'h0, '0);
        quiet_check("R11 deselected after sleep");
        p_read(4'h0, "R11 contents kept");
        p_read(4'h1, "R11 contents kept");

        desel();
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R10 missing reads", DW'(exp_q.size()), '0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule